// File: doc/BRIEF.md
# ATA Status Polling Engine

This block runs on the host side of an ATA channel after a command has already been written. It reads the channel registers over a simple byte-wide register bus and reports how the command ended. The bus has a one-cycle read strobe, a 3-bit register offset and a select bit that picks the control block or the command block. First the engine waits for the device to settle. It does this by reading the alternate status register four times, and this register read has no side effects. It then reads the status register again and again until the busy bit reads zero.

If the advanced check was requested with the start pulse, the engine takes one more status sample and sorts it into a result code. The code says whether the device reported an error, reported a fault, failed to raise its data request, or finished cleanly. A programmable poll limit stops the wait on a device that never leaves busy. The outcome is presented as a 3-bit code that is qualified by a one-cycle done pulse.

The state machine has eight states:

- `ST_IDLE` waits for start.
- `ST_SETTLE_RD` and `ST_SETTLE_WT` issue and complete each settle read.
- `ST_POLL_RD` and `ST_POLL_WT` issue and complete each busy poll.
- `ST_CHECK_RD` and `ST_CHECK_WT` take the extra sample for the advanced check.
- `ST_REPORT` raises done.

The transitions are:

- IDLE to SETTLE_RD on start.
- SETTLE_RD to SETTLE_WT.
- SETTLE_WT back to SETTLE_RD until the fourth settle read, then to POLL_RD.
- POLL_RD to POLL_WT.
- POLL_WT back to POLL_RD while busy.
- POLL_WT to REPORT on a timeout, or on a not-busy sample when the advanced check is off.
- POLL_WT to CHECK_RD on a not-busy sample when the advanced check is on.
- CHECK_RD to CHECK_WT.
- CHECK_WT to REPORT.
- REPORT to IDLE.

Top module: `ata_status_poller`

## Requirements
- R1: After reset the engine is idle: `bus_rd_o` and `done_o` are 0 and no read is issued until start.
- R2: After start, exactly four reads with `bus_sel_ctrl_o`=1 and `bus_addr_o`=2 (alternate status) are issued, and they come before any status read.
- R3: The engine then reads with `bus_sel_ctrl_o`=0 and `bus_addr_o`=7 (status) and keeps polling while bit 7 (busy) of the returned byte is 1. Other bits are ignored while busy is set.
- R4: Each read is a one-cycle strobe. Its data is sampled on `bus_rdata_i` in the cycle after the strobe, and a strobe is never asserted in two consecutive cycles. The time from the start edge to `done_o` is therefore 9 + 2 × (status reads) cycles.
- R5: With the advanced check off, the result is 0 as soon as a status read shows busy clear, with no further read.
- R6: With the advanced check on, exactly one further status read is taken. If its bit 0 (error) is 1, the result is 2, whatever the other bits are.
- R7: With the advanced check on and bit 0 clear, bit 5 (fault) set gives result 1.
- R8: With the advanced check on and bits 0 and 5 clear, bit 3 (data request) clear gives result 3 and bit 3 set gives result 0.
- R9: `done_o` is high for exactly one cycle, and `result_o` is valid in that cycle. The engine then returns to idle and issues no reads.
- R10: A start pulse while the engine is busy is ignored. The advanced-check flag and the poll limit are captured at the accepted start.
- R11: With a poll limit L > 0, the L-th consecutive busy status read ends the command with result 4. L = 0 disables the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse to begin waiting on the channel |
| adv_chk_i | input | 1 | Classify the final status; captured with start |
| poll_limit_i | input | TMO_W | Busy-poll limit, 0 = unlimited; captured with start |
| bus_rd_o | output | 1 | Read strobe, one cycle per read |
| bus_sel_ctrl_o | output | 1 | 1 = control block, 0 = command block |
| bus_addr_o | output | 3 | Register offset within the selected block |
| bus_rdata_i | input | 8 | Read data, valid the cycle after the strobe |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 3 | 0 ok, 1 fault, 2 error, 3 no data request, 4 timeout |

## Verification
The tests use status bytes that set the error, fault and data-request bits together and separately, so that each step of the priority order is separated from the next. While the device is busy it returns 0x89, which has the error and data-request bits set. This shows that only the busy bit matters during polling. Runs with the advanced check off return 0 even when the final byte carries an error, and the count of status reads separates the plain exit from the checked one. Poll limits set exactly at, and one above, the number of busy reads find the edge of the timeout. A second start pulse sent mid-run with different settings shows that the captured settings are the ones used.

// File: rtl/ata_poll_pkg.sv
package ata_poll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE_RD,
        ST_SETTLE_WT,
        ST_POLL_RD,
        ST_POLL_WT,
        ST_CHECK_RD,
        ST_CHECK_WT,
        ST_REPORT
    } poll_state_e;

    localparam logic [2:0] RES_OK      = 3'd0;
    localparam logic [2:0] RES_FAULT   = 3'd1;
    localparam logic [2:0] RES_ERROR   = 3'd2;
    localparam logic [2:0] RES_NO_DRQ  = 3'd3;
    localparam logic [2:0] RES_TIMEOUT = 3'd4;

    localparam int unsigned STAT_BUSY_BIT = 7;

    localparam logic [2:0] OFS_STATUS  = 3'd7;
    localparam logic [2:0] OFS_ALTSTAT = 3'd2;

endpackage

// File: rtl/ata_poll_counter.sv
module ata_poll_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clr_i) begin
            count_o <= '0;
        end else if (inc_i) begin
            count_o <= count_o + 1'b1;
        end
    end
endmodule

// File: rtl/ata_status_classify.sv
module ata_status_classify
    import ata_poll_pkg::*;
(
    input  logic [7:0] status_i,
    output logic [2:0] code_o
);
    // Error outranks fault, fault outranks a missing data request.
    always_comb begin
        priority casez (status_i)
            8'b???????1: code_o = RES_ERROR;
            8'b??1?????: code_o = RES_FAULT;
            8'b????0???: code_o = RES_NO_DRQ;
            default:     code_o = RES_OK;
        endcase
    end
endmodule

// File: rtl/ata_status_poller.sv
module ata_status_poller
    import ata_poll_pkg::*;
#(
    parameter int SETTLE_READS = 4,
    parameter int TMO_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             adv_chk_i,
    input  logic [TMO_W-1:0] poll_limit_i,
    output logic             bus_rd_o,
    output logic             bus_sel_ctrl_o,
    output logic [2:0]       bus_addr_o,
    input  logic [7:0]       bus_rdata_i,
    output logic             done_o,
    output logic [2:0]       result_o
);
    localparam int SET_W = $clog2(SETTLE_READS + 1);
    localparam logic [SET_W-1:0] SETTLE_LAST = SET_W'(SETTLE_READS - 1);

    poll_state_e      state_q, state_d;
    logic             adv_q;
    logic [TMO_W-1:0] limit_q;
    logic [2:0]       result_q, result_d;
    logic [SET_W-1:0] settle_cnt;
    logic [TMO_W-1:0] poll_cnt;
    logic [2:0]       class_code;
    logic             busy_seen;
    logic             limit_hit;

    ata_poll_counter #(.W(SET_W)) u_settle_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (state_q == ST_IDLE),
        .inc_i   (state_q == ST_SETTLE_WT),
        .count_o (settle_cnt)
    );

    ata_poll_counter #(.W(TMO_W)) u_poll_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (state_q == ST_IDLE),
        .inc_i   ((state_q == ST_POLL_WT) && busy_seen),
        .count_o (poll_cnt)
    );

    ata_status_classify u_classify (
        .status_i (bus_rdata_i),
        .code_o   (class_code)
    );

    assign busy_seen = bus_rdata_i[STAT_BUSY_BIT];
    assign limit_hit = (limit_q != '0) && (TMO_W'(poll_cnt + 1'b1) == limit_q);

    // Next state and result selection
    always_comb begin
        state_d  = state_q;
        result_d = result_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_SETTLE_RD;
            ST_SETTLE_RD: state_d = ST_SETTLE_WT;
            ST_SETTLE_WT: state_d = (settle_cnt == SETTLE_LAST) ? ST_POLL_RD : ST_SETTLE_RD;
            ST_POLL_RD:   state_d = ST_POLL_WT;
            ST_POLL_WT: begin
                if (busy_seen) begin
                    if (limit_hit) begin
                        state_d  = ST_REPORT;
                        result_d = RES_TIMEOUT;
                    end else begin
                        state_d = ST_POLL_RD;
                    end
                end else if (adv_q) begin
                    state_d = ST_CHECK_RD;
                end else begin
                    state_d  = ST_REPORT;
                    result_d = RES_OK;
                end
            end
            ST_CHECK_RD:  state_d = ST_CHECK_WT;
            ST_CHECK_WT: begin
                state_d  = ST_REPORT;
                result_d = class_code;
            end
            ST_REPORT:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register and captured settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            adv_q    <= 1'b0;
            limit_q  <= '0;
            result_q <= RES_OK;
        end else begin
            state_q  <= state_d;
            result_q <= result_d;
            if (state_q == ST_IDLE && start_i) begin
                adv_q   <= adv_chk_i;
                limit_q <= poll_limit_i;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        bus_rd_o       = 1'b0;
        bus_sel_ctrl_o = 1'b0;
        bus_addr_o     = OFS_STATUS;
        done_o         = 1'b0;
        unique case (state_q)
            ST_SETTLE_RD: begin
                bus_rd_o       = 1'b1;
                bus_sel_ctrl_o = 1'b1;
                bus_addr_o     = OFS_ALTSTAT;
            end
            ST_POLL_RD, ST_CHECK_RD: bus_rd_o = 1'b1;
            ST_REPORT:    done_o = 1'b1;
            default: ;
        endcase
    end

    assign result_o = result_q;

endmodule

// File: rtl/ata_poll_chk.sv
module ata_poll_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_rd_o,
    input logic       bus_sel_ctrl_o,
    input logic [2:0] bus_addr_o,
    input logic       done_o,
    input logic [2:0] result_o
);
    // R4
    no_back_to_back_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_o |=> !bus_rd_o);

    // R9
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_result_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (result_o <= 3'd4) && !bus_rd_o);

    // R9
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !bus_rd_o);

    // R2
    alt_status_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_o && bus_sel_ctrl_o) |-> (bus_addr_o == 3'd2));

    // R3
    status_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_o && !bus_sel_ctrl_o) |-> (bus_addr_o == 3'd7));
endmodule

bind ata_status_poller ata_poll_chk u_poll_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_rd_o       (bus_rd_o),
    .bus_sel_ctrl_o (bus_sel_ctrl_o),
    .bus_addr_o     (bus_addr_o),
    .done_o         (done_o),
    .result_o       (result_o)
);

// File: tb/test_ata_status_poller.sv
`timescale 1ns/1ps
module test_ata_status_poller;
    localparam int TMO_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             adv_chk_i = 1'b0;
    logic [TMO_W-1:0] poll_limit_i = '0;
    logic             bus_rd_o, bus_sel_ctrl_o, done_o;
    logic [2:0]       bus_addr_o, result_o;
    logic [7:0]       bus_rdata_i = 8'h00;

    int total = 0;
    int bad = 0;

    // device model state
    int         busy_left = 0;
    logic [7:0] final_stat = 8'h00;
    int         alt_cnt = 0;
    int         stat_cnt = 0;
    int         order_bad = 0;
    int         addr_bad = 0;
    int         b2b_bad = 0;
    int         done_cnt = 0;
    logic       rd_prev = 1'b0;

    always #2.5 clk = ~clk;

    ata_status_poller #(.SETTLE_READS(4), .TMO_W(TMO_W)) i_ata_status_poller (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .adv_chk_i      (adv_chk_i),
        .poll_limit_i   (poll_limit_i),
        .bus_rd_o       (bus_rd_o),
        .bus_sel_ctrl_o (bus_sel_ctrl_o),
        .bus_addr_o     (bus_addr_o),
        .bus_rdata_i    (bus_rdata_i),
        .done_o         (done_o),
        .result_o       (result_o)
    );

    // Register-bus device: data appears the cycle after the strobe.
    always @(posedge clk) begin
        if (rd_prev && bus_rd_o) b2b_bad++;
        rd_prev = bus_rd_o;
        if (done_o) done_cnt++;
        if (bus_rd_o) begin
            if (bus_sel_ctrl_o) begin
                alt_cnt++;
                if (bus_addr_o != 3'd2) addr_bad++;
                bus_rdata_i <= (busy_left > 0) ? 8'h89 : final_stat;
            end else begin
                stat_cnt++;
                if (alt_cnt < 4) order_bad++;
                if (bus_addr_o != 3'd7) addr_bad++;
                if (busy_left > 0) begin
                    bus_rdata_i <= 8'h89;
                    busy_left--;
                end else begin
                    bus_rdata_i <= final_stat;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic prep(input int busy_n, input logic [7:0] fstat);
        busy_left  = busy_n;
        final_stat = fstat;
        alt_cnt    = 0;
        stat_cnt   = 0;
        order_bad  = 0;
        addr_bad   = 0;
        done_cnt   = 0;
    endtask

    task automatic pulse_start(input bit adv, input int limit);
        @(negedge clk);
        adv_chk_i    = adv;
        poll_limit_i = TMO_W'(limit);
        start_i      = 1'b1;
        @(negedge clk);
        start_i      = 1'b0;
    endtask

    // Counts negedges from the start edge until done is seen.
    task automatic wait_done(output int lat, output bit seen);
        lat  = 1;
        seen = 1'b0;
        while (lat < 5000) begin
            if (done_o) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic finish_checks(input string req, input int exp_code, input int exp_reads,
                                 input int lat, input bit seen);
        check(seen, {req, " done seen"}, seen, 1);
        check(result_o == 3'(exp_code), {req, " result"}, result_o, exp_code);
        check(alt_cnt == 4, "R2 settle read count", alt_cnt, 4);
        check(order_bad == 0, "R2 status before settle", order_bad, 0);
        check(stat_cnt == exp_reads, {req, " R3 status read count"}, stat_cnt, exp_reads);
        check(lat == 9 + 2 * exp_reads, "R4 latency", lat, 9 + 2 * exp_reads);
        @(negedge clk);
        check(done_o == 1'b0, "R9 done one cycle", done_o, 0);
        check(addr_bad == 0 && b2b_bad == 0, "R4 strobe form", addr_bad + b2b_bad, 0);
    endtask

    task automatic run_cmd(input string req, input bit adv, input int busy_n,
                           input logic [7:0] fstat, input int limit,
                           input int exp_code, input int exp_reads);
        int lat;
        bit seen;
        prep(busy_n, fstat);
        pulse_start(adv, limit);
        wait_done(lat, seen);
        finish_checks(req, exp_code, exp_reads, lat, seen);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(bus_rd_o == 1'b0, "R1 no read in reset", bus_rd_o, 0);
        check(done_o == 1'b0, "R1 done low in reset", done_o, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(bus_rd_o == 1'b0 && alt_cnt == 0 && stat_cnt == 0, "R1 idle without start",
              alt_cnt + stat_cnt, 0);
    endtask

    task automatic t_start_ignored;
        int lat;
        bit seen;
        prep(6, 8'h40);
        pulse_start(1'b1, 0);
        repeat (10) @(negedge clk);
        adv_chk_i    = 1'b0;
        poll_limit_i = TMO_W'(2);
        start_i      = 1'b1;
        @(negedge clk);
        start_i      = 1'b0;
        lat = 12;
        while (lat < 5000 && !done_o) begin
            @(negedge clk);
            lat++;
        end
        seen = done_o;
        // captured adv=1 and limit=0: 6 busy + 1 clear + 1 check, result 3
        finish_checks("R10", 3, 8, lat, seen);
        repeat (20) @(negedge clk);
        check(done_cnt == 1, "R10 one completion", done_cnt, 1);
        check(stat_cnt == 8 && alt_cnt == 4, "R9 no reads after done", stat_cnt, 8);
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        run_cmd("R5 plain clear", 1'b0, 0, 8'h00, 0, 0, 1);
        run_cmd("R5 error unchecked", 1'b0, 3, 8'h01, 0, 0, 4);
        run_cmd("R6 error first", 1'b1, 2, 8'h29, 0, 2, 4);
        run_cmd("R7 fault", 1'b1, 1, 8'h28, 0, 1, 3);
        run_cmd("R8 no drq", 1'b1, 0, 8'h40, 0, 3, 2);
        run_cmd("R8 drq ok", 1'b1, 4, 8'h48, 0, 0, 6);
        run_cmd("R11 timeout", 1'b1, 1000, 8'h00, 3, 4, 3);
        run_cmd("R11 unlimited", 1'b0, 6, 8'h00, 0, 0, 7);
        run_cmd("R11 limit above", 1'b0, 6, 8'h00, 7, 0, 7);
        run_cmd("R11 limit equal", 1'b1, 6, 8'h48, 6, 4, 6);
        t_start_ignored();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule